// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between a memory controller's command scheduler and the column address pins of a synchronous DRAM. It keeps the operating fields of the device's mode word and expands each read or write command into the column address of every beat of the burst. It also gives the beat its place in the wrap order, marks the final beat, and raises a data-valid strobe that trails the read columns by the programmed CAS latency.

A mode word is loaded with `mode_ld`. A command is given as a one-cycle `cmd_go` pulse together with `cmd_wr` and the starting column. The first column appears on `col_out` in the cycle after the command is sampled, and each later beat follows one cycle after the one before it. A `cmd_stop` pulse cuts a burst short. A fresh command ends the running burst and replaces it without a gap. The burst length, the wrap type, the latency and the write direction are captured when the command is taken. A mode load that arrives later therefore affects only the bursts that start after it.

The controller has three states. ST_IDLE issues nothing. ST_BURST issues the beats of a fixed-length burst. ST_PAGE issues full-page beats. The transitions are as follows:
- A command with an effective length of one stays in or returns to ST_IDLE.
- A command with a length of 2, 4 or 8 goes to ST_BURST.
- A full-page command goes to ST_PAGE.
- ST_BURST goes back to ST_IDLE after its last beat or on a stop.
- ST_PAGE goes back to ST_IDLE only on a stop.
- A command accepted in any state restarts the burst from that command.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_vld`, `last_beat` and `data_vld` are 0. The mode in force is burst length 1, sequential, latency 2, with writes following the burst length.
- R2: A load decodes `mode_val` as follows:
  - Bits 2:0 give the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page.
  - Bit 3 selects the wrap type: 1 is interleaved and 0 is sequential.
  - Bits 6:4 give the latency: 010 gives 2 and 011 gives 3.
  - Bit 9 set makes writes single-beat.
  - Bits 12:10 are ignored.
  - A load is ignored, and the previous mode kept, if any of these holds: the length code is reserved, the latency code is reserved, bits 8:7 are not 00, or full page is combined with interleaved.
- R3: In the cycle after `cmd_go` is sampled, `col_vld` is 1 and `col_out` equals the sampled `cmd_col`.
- R4: In a sequential burst of length L (2, 4 or 8), beat k has the starting column's upper bits with low bits (start + k) mod L.
- R5: In an interleaved burst of length L, beat k has the starting column's upper bits with low bits (start XOR k).
- R6: A full-page burst issues start, start+1 and so on, wrapping modulo 2^COL_W, until a stop or a new command. It never raises `last_beat`.
- R7: `last_beat` is 1 exactly with the final beat of a fixed-length burst. The next cycle carries no column unless a new command was sampled, which may follow with no gap.
- R8: A stop sampled during a burst leaves no column valid in the next cycle. A stop sampled while idle has no effect.
- R9: A command sampled during a burst, with or without a simultaneous stop, starts the new burst in the next cycle.
- R10: With bit 9 set, a write issues one beat with `last_beat` set, while reads keep the programmed length.
- R11: `data_vld` is 1 exactly L cycles after each read column, where L is the latency captured for that burst. It is 1 in the same cycle as each write column.
- R12: A mode load during a burst does not alter the length, order or latency of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_val | input | 13 | Mode word |
| cmd_go | input | 1 | Read or write command strobe |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| cmd_col | input | COL_W | Starting column |
| cmd_stop | input | 1 | Burst stop strobe |
| col_out | output | COL_W | Column of the current beat |
| col_vld | output | 1 | A beat is issued this cycle |
| last_beat | output | 1 | Current beat is the final one |
| data_vld | output | 1 | Data window strobe (latency-delayed for reads) |

## Verification
Some properties are checked on every cycle by the assertions:
- the first column follows the command,
- a final beat is always a valid beat,
- a final beat or a stop empties the next cycle,
- consecutive beats inside one burst never repeat a column,
- a write command yields a same-cycle data strobe.

The exact wrap orders, the decoding and rejection of mode words, the single-beat write mode, the read latency and the isolation of a running burst from a mode load are shown only by the bench's scenarios. In those scenarios a behavioural model predicts every output cycle by cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int MODE_W = 13;

    // Field positions inside the mode word (decoded by neighbours)
    localparam int BL_LSB = 0;
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int TM_LSB = 7;
    localparam int WS_BIT = 9;

    localparam logic [2:0] BL_ONE   = 3'b000;
    localparam logic [2:0] BL_TWO   = 3'b001;
    localparam logic [2:0] BL_FOUR  = 3'b010;
    localparam logic [2:0] BL_EIGHT = 3'b011;
    localparam logic [2:0] BL_PAGE  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcs_state_e;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MAX_CL = 3,
    parameter int CLW    = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [MODE_W-1:0] val,
    output logic [COL_W-1:0]  m_mask,
    output logic              m_page,
    output logic              m_ilv,
    output logic [CLW-1:0]    m_cl,
    output logic              m_ws
);
    logic [2:0]       bl_code;
    logic [2:0]       cl_code;
    logic [1:0]       tm_code;
    logic             bl_ok;
    logic             cl_ok;
    logic             accept;
    logic [COL_W-1:0] mask_dec;

    always_comb begin
        bl_code  = val[BL_LSB +: 3];
        cl_code  = val[CL_LSB +: 3];
        tm_code  = val[TM_LSB +: 2];
        bl_ok    = 1'b1;
        mask_dec = '0;
        unique case (bl_code)
            BL_ONE:   mask_dec = '0;
            BL_TWO:   mask_dec = COL_W'(1);
            BL_FOUR:  mask_dec = COL_W'(3);
            BL_EIGHT: mask_dec = COL_W'(7);
            BL_PAGE:  mask_dec = '1;
            default:  bl_ok    = 1'b0;
        endcase
        cl_ok  = (int'(cl_code) >= 2) && (int'(cl_code) <= MAX_CL);
        accept = ld && bl_ok && cl_ok && (tm_code == 2'b00)
                 && !((bl_code == BL_PAGE) && val[BT_BIT]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_mask <= '0;
            m_page <= 1'b0;
            m_ilv  <= 1'b0;
            m_cl   <= CLW'(2);
            m_ws   <= 1'b0;
        end else if (accept) begin
            m_mask <= mask_dec;
            m_page <= (bl_code == BL_PAGE);
            m_ilv  <= val[BT_BIT];
            m_cl   <= CLW'(cl_code);
            m_ws   <= val[WS_BIT];
        end
    end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low;

    always_comb begin
        low = ilv ? (base ^ beat) : (base + beat);
        col = (base & ~mask) | (low & mask);
    end
endmodule

// File: rtl/bcs_rd_delay.sv
module bcs_rd_delay #(
    parameter int MAX_CL = 3,
    parameter int CLW    = $clog2(MAX_CL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue,
    input  logic [CLW-1:0] lat,
    output logic           dv
);
    logic [MAX_CL:0] pipe_q;
    logic [MAX_CL:0] pipe_n;

    for (genvar i = 0; i <= MAX_CL; i++) begin : g_slot
        if (i < MAX_CL) begin : g_mid
            assign pipe_n[i] = pipe_q[i+1] | (issue && (int'(lat) == i));
        end else begin : g_top
            assign pipe_n[i] = issue && (int'(lat) == i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_n;
    end

    assign dv = pipe_q[0];
endmodule

// File: rtl/bcs_burst_fsm.sv
module bcs_burst_fsm
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int CLW   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] m_mask,
    input  logic             m_page,
    input  logic             m_ilv,
    input  logic [CLW-1:0]   m_cl,
    input  logic             m_ws,
    output logic [COL_W-1:0] col_q,
    output logic             vld_q,
    output logic             last_q,
    output logic             wr_q,
    output logic             issue_rd,
    output logic [CLW-1:0]   issue_cl
);
    bcs_state_e       st_q, st_n;
    logic [COL_W-1:0] start_q, start_n;
    logic [COL_W-1:0] beat_q, beat_n;
    logic [COL_W-1:0] mask_q, mask_n;
    logic             ilv_q, ilv_n;
    logic [CLW-1:0]   cl_q, cl_n;
    logic             wr_n;
    logic [COL_W-1:0] col_n;
    logic             vld_n, last_n;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] gen_col;
    logic             one_wr;

    assign beat_inc = beat_q + COL_W'(1);

    bcs_col_gen #(.COL_W(COL_W)) u_gen (
        .base (start_q),
        .beat (beat_inc),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (gen_col)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            start_q <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            cl_q    <= CLW'(2);
            wr_q    <= 1'b0;
            col_q   <= '0;
            vld_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            start_q <= start_n;
            beat_q  <= beat_n;
            mask_q  <= mask_n;
            ilv_q   <= ilv_n;
            cl_q    <= cl_n;
            wr_q    <= wr_n;
            col_q   <= col_n;
            vld_q   <= vld_n;
            last_q  <= last_n;
        end
    end

    // Next state and outputs
    always_comb begin
        st_n    = st_q;
        start_n = start_q;
        beat_n  = beat_q;
        mask_n  = mask_q;
        ilv_n   = ilv_q;
        cl_n    = cl_q;
        wr_n    = wr_q;
        col_n   = col_q;
        vld_n   = 1'b0;
        last_n  = 1'b0;
        one_wr  = cmd_wr & m_ws;
        if (cmd_go) begin
            start_n = cmd_col;
            beat_n  = '0;
            mask_n  = one_wr ? '0 : m_mask;
            ilv_n   = m_ilv;
            cl_n    = m_cl;
            wr_n    = cmd_wr;
            col_n   = cmd_col;
            vld_n   = 1'b1;
            if (!one_wr && m_page) begin
                st_n = ST_PAGE;
            end else if (mask_n == '0) begin
                st_n   = ST_IDLE;
                last_n = 1'b1;
            end else begin
                st_n = ST_BURST;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: st_n = ST_IDLE;
                ST_BURST: begin
                    if (cmd_stop) begin
                        st_n = ST_IDLE;
                    end else begin
                        beat_n = beat_inc;
                        col_n  = gen_col;
                        vld_n  = 1'b1;
                        if (beat_inc == mask_q) begin
                            last_n = 1'b1;
                            st_n   = ST_IDLE;
                        end
                    end
                end
                ST_PAGE: begin
                    if (cmd_stop) begin
                        st_n = ST_IDLE;
                    end else begin
                        beat_n = beat_inc;
                        col_n  = gen_col;
                        vld_n  = 1'b1;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
        issue_rd = vld_n & ~wr_n;
        issue_cl = cl_n;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [12:0]       mode_val,
    input  logic              cmd_go,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_vld,
    output logic              last_beat,
    output logic              data_vld
);
    localparam int CLW = $clog2(MAX_CL + 1);

    logic [COL_W-1:0] m_mask;
    logic             m_page, m_ilv, m_ws;
    logic [CLW-1:0]   m_cl;
    logic             wr_q, issue_rd, rd_dv;
    logic [CLW-1:0]   issue_cl;

    bcs_mode_reg #(.COL_W(COL_W), .MAX_CL(MAX_CL), .CLW(CLW)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (mode_ld),
        .val    (mode_val),
        .m_mask (m_mask),
        .m_page (m_page),
        .m_ilv  (m_ilv),
        .m_cl   (m_cl),
        .m_ws   (m_ws)
    );

    bcs_burst_fsm #(.COL_W(COL_W), .CLW(CLW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .cmd_wr   (cmd_wr),
        .cmd_col  (cmd_col),
        .cmd_stop (cmd_stop),
        .m_mask   (m_mask),
        .m_page   (m_page),
        .m_ilv    (m_ilv),
        .m_cl     (m_cl),
        .m_ws     (m_ws),
        .col_q    (col_out),
        .vld_q    (col_vld),
        .last_q   (last_beat),
        .wr_q     (wr_q),
        .issue_rd (issue_rd),
        .issue_cl (issue_cl)
    );

    bcs_rd_delay #(.MAX_CL(MAX_CL), .CLW(CLW)) u_rdly (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue_rd),
        .lat   (issue_cl),
        .dv    (rd_dv)
    );

    assign data_vld = rd_dv | (col_vld & wr_q);
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_go,
    input logic             cmd_wr,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_vld,
    input logic             last_beat,
    input logic             data_vld
);
    // R3
    first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (col_vld && col_out == $past(cmd_col)));

    // R7
    last_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_vld);

    // R7
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_go) |=> !col_vld);

    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_go) |=> !col_vld);

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && $past(col_vld) && !$past(cmd_go)) |-> (col_out != $past(col_out)));

    // R11
    wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_wr) |=> data_vld);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd_wr    (cmd_wr),
    .cmd_col   (cmd_col),
    .cmd_stop  (cmd_stop),
    .col_out   (col_out),
    .col_vld   (col_vld),
    .last_beat (last_beat),
    .data_vld  (data_vld)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
    localparam int COL_W = 10;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_ld = 1'b0;
    logic [12:0]      mode_val = '0;
    logic             cmd_go = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_vld, last_beat, data_vld;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MAX_CL(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_val(mode_val),
        .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
        .col_out(col_out), .col_vld(col_vld), .last_beat(last_beat), .data_vld(data_vld)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // Reference model state
    int m_len = 1; bit m_page = 0; bit m_ilv = 0; int m_cl = 2; bit m_ws = 0;
    bit act = 0; int b_start = 0; int b_beat = 0; int b_len = 1;
    bit b_page = 0; bit b_ilv = 0; int b_cl = 2; bit b_wr = 0;
    bit e_vld = 0; int e_col = 0; bit e_last = 0; bit e_dv = 0;
    int cyc = 0;
    int rdq[$];

    function automatic int col_for(int beat);
        int off, base;
        if (b_page) return (b_start + beat) % NCOL;
        off  = b_start % b_len;
        base = b_start - off;
        if (b_ilv) return base + (off ^ beat);
        return base + ((off + beat) % b_len);
    endfunction

    task automatic model_step();
        int n;
        int len_new;
        bit ok;
        int cl_new;
        n = cyc + 1;
        if (cmd_go) begin
            b_start = cmd_col; b_beat = 0; b_wr = cmd_wr; b_ilv = m_ilv; b_cl = m_cl;
            if (cmd_wr && m_ws) begin b_page = 0; b_len = 1; end
            else begin b_page = m_page; b_len = m_len; end
            e_vld = 1; e_col = cmd_col;
            e_last = !b_page && (b_len == 1);
            act = !e_last;
        end else if (act && cmd_stop) begin
            act = 0; e_vld = 0; e_last = 0;
        end else if (act) begin
            b_beat++;
            e_vld = 1; e_col = col_for(b_beat);
            e_last = !b_page && (b_beat == b_len - 1);
            if (e_last) act = 0;
        end else begin
            e_vld = 0; e_last = 0;
        end
        if (e_vld && !b_wr) rdq.push_back(n + b_cl);
        if (mode_ld) begin
            ok = 1; len_new = 0;
            case (mode_val[2:0])
                3'd0: len_new = 1;
                3'd1: len_new = 2;
                3'd2: len_new = 4;
                3'd3: len_new = 8;
                3'd7: len_new = 0;
                default: ok = 0;
            endcase
            cl_new = int'(mode_val[6:4]);
            if (cl_new != 2 && cl_new != 3) ok = 0;
            if (mode_val[8:7] != 2'b00) ok = 0;
            if (mode_val[2:0] == 3'd7 && mode_val[3]) ok = 0;
            if (ok) begin
                m_page = (mode_val[2:0] == 3'd7);
                m_len  = len_new; m_ilv = mode_val[3]; m_cl = cl_new; m_ws = mode_val[9];
            end
        end
        cyc = n;
        e_dv = e_vld && b_wr;
        foreach (rdq[i]) if (rdq[i] == n) e_dv = 1;
        while (rdq.size() > 0 && rdq[0] <= n) void'(rdq.pop_front());
    endtask

    task automatic compare();
        bit ok;
        checks++;
        ok = (col_vld === e_vld) && (last_beat === e_last) && (data_vld === e_dv)
             && (!e_vld || col_out === COL_W'(e_col));
        if (!ok) begin
            fails++;
            $display("FAIL %s cyc %0d: vld=%0b/%0b col=%h/%h last=%0b/%0b dv=%0b/%0b (actual/expected)",
                     cur_req, cyc, col_vld, e_vld, col_out, COL_W'(e_col), last_beat, e_last, data_vld, e_dv);
        end
    endtask

    task automatic step(input bit go, input bit wr, input int col, input bit stop,
                        input bit ld, input int val);
        cmd_go = go; cmd_wr = wr; cmd_col = COL_W'(col); cmd_stop = stop;
        mode_ld = ld; mode_val = 13'(val);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic load(input int val);
        step(0, 0, 0, 0, 1, val);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1"; compare();
        step(1, 0, 'h012, 0, 0, 0); idle(4);            // R1 default: BL1, CL2

        cur_req = "R4"; load('h032);                    // BL4 seq CL3
        step(1, 0, 'h0A6, 0, 0, 0); idle(7);            // R4 R11
        cur_req = "R5"; load('h02B);                    // BL8 interleaved CL2
        step(1, 0, 'h1F5, 0, 0, 0); idle(10);
        cur_req = "R11"; load('h031);                   // BL2 seq CL3
        step(1, 1, 'h003, 0, 0, 0); idle(3);            // write strobe same cycle

        cur_req = "R2";
        load('h024); load('h013); load('h0A3); load('h02F);
        step(1, 0, 'h041, 0, 0, 0); idle(5);            // still BL2 CL3
        load('h1C22);                                   // high bits ignored: BL4 CL2
        step(1, 0, 'h10B, 0, 0, 0); idle(6);

        cur_req = "R10"; load('h223);                   // BL8 seq, single writes
        step(1, 1, 'h005, 0, 0, 0); idle(2);
        step(1, 0, 'h005, 0, 0, 0); idle(10);

        cur_req = "R6"; load('h027);                    // full page seq CL2
        step(1, 0, 'h3FD, 0, 0, 0); idle(6);
        cur_req = "R8"; step(0, 0, 0, 1, 0, 0); idle(3);
        step(0, 0, 0, 1, 0, 0); idle(2);                // stop while idle

        cur_req = "R9"; load('h023);                    // BL8 seq CL2
        step(1, 0, 'h100, 0, 0, 0); idle(2);
        step(1, 1, 'h208, 0, 0, 0); idle(2);
        step(1, 0, 'h30C, 1, 0, 0); idle(10);           // stop and go together

        cur_req = "R12";
        step(1, 0, 'h300, 0, 0, 0);
        load('h020);                                    // BL1 mid-burst
        idle(9);
        step(1, 0, 'h301, 0, 0, 0); idle(3);

        cur_req = "R7"; load('h022);                    // BL4 seq CL2
        step(1, 0, 'h010, 0, 0, 0); idle(3);
        step(1, 0, 'h020, 0, 0, 0); idle(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung (actual running, expected finished)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule